// File: doc/BRIEF.md
# Fixed-Point PI Control Law

This block evaluates a proportional-integral control law once per sample. When the sample strobe is high, it reads a setpoint and a measured position. Both are signed integers in hundredths of the physical unit. The block forms their difference and scales that difference by two fixed rational gains. It then returns an actuator command in thousandths of the actuator unit.

The proportional gain is 64/125 and the integral gain is 51/1250. These values assume a 0.1 s sample period. Each gain is applied as an exact integer multiply followed by a signed integer divide. The divide truncates toward zero.

The integral term is a 32-bit accumulator. It is updated once per strobe, and the command for a sample uses the updated integral. All intermediate sums are computed at 32 bits with saturation. The final sum is clamped to the signed 16-bit range before it is narrowed. The command is registered, and a one-cycle valid pulse marks each new result.

Top module: `pi_fixed_loop`

## Requirements
- R1: While the synchronous reset `rst` is high, at the next clock edge the command goes to 0, the valid flag goes to 0 and the integral accumulator is cleared to 0.
- R2: The error for a sample is `setpt_i - meas_i`, taken as signed two's-complement values sign-extended to 32 bits. Its range is -65535 to +65535.
- R3: The proportional term is `(64 * e) / 125`, with the quotient truncated toward zero. For example, an error of -2 yields -1, not -2.
- R4: On each strobe the integral becomes its previous value plus `(51 * e) / 1250`, truncated toward zero. Small errors (|e| < 25) therefore leave it unchanged.
- R5: The command is the proportional term plus the integral value that this sample has just updated, not the previous integral value.
- R6: A sum above +32767 gives a command of exactly +32767. A sum below -32768 gives a command of exactly -32768.
- R7: `cmd_vld_o` is high in the cycle after each cycle with `tick_i` high, and low otherwise. Back-to-back strobes give back-to-back results.
- R8: Without a strobe, the command and the integral hold their values. Input changes while `tick_i` is low have no effect.
- R9: A reset applied mid-run discards the accumulated integral. The first sample after reset behaves as if from power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Sample strobe, one evaluation per high cycle |
| setpt_i | input | DATA_W (16) | Signed setpoint, units of 0.01 |
| meas_i | input | DATA_W (16) | Signed measured position, units of 0.01 |
| cmd_o | output | DATA_W (16) | Signed actuator command, units of 0.001 |
| cmd_vld_o | output | 1 | One-cycle pulse marking a new command |

## Verification
The bench builds the block with its default parameters: 16-bit data, gains 64/125 and 51/1250, and a 32-bit accumulator. At this width the full-scale error of ±65535 can be driven directly. That error makes the proportional term alone exceed the output range, and a few dozen strobes at that error wind the integral far past it. Both clamp directions and the return from saturation are therefore reached quickly.

Negative errors near zero exercise truncation toward zero. A run of small errors shows that the integral ignores contributions below one count.

// File: rtl/pi_pkg.sv
package pi_pkg;

    // Accumulator and intermediate arithmetic width.
    localparam int PI_ACC_W = 32;

    typedef logic signed [PI_ACC_W-1:0] pi_acc_t;

    localparam pi_acc_t PI_ACC_MAX = {1'b0, {(PI_ACC_W-1){1'b1}}};
    localparam pi_acc_t PI_ACC_MIN = {1'b1, {(PI_ACC_W-1){1'b0}}};

    // Saturating signed add at accumulator width.
    function automatic pi_acc_t pi_sat_add(input pi_acc_t a, input pi_acc_t b);
        logic signed [PI_ACC_W:0] s;
        s = {a[PI_ACC_W-1], a} + {b[PI_ACC_W-1], b};
        if (s[PI_ACC_W] != s[PI_ACC_W-1])
            return s[PI_ACC_W] ? PI_ACC_MIN : PI_ACC_MAX;
        return s[PI_ACC_W-1:0];
    endfunction

endpackage

// File: rtl/pi_err_calc.sv
module pi_err_calc
    import pi_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] setpt_i,
    input  logic signed [DATA_W-1:0] meas_i,
    output pi_acc_t                  err_o
);

    pi_acc_t setpt_w;
    pi_acc_t meas_w;

    // Sign-extend both operands before subtracting, so the difference cannot wrap.
    always_comb begin
        setpt_w = pi_acc_t'(setpt_i);
        meas_w  = pi_acc_t'(meas_i);
        err_o   = setpt_w - meas_w;
    end

endmodule

// File: rtl/pi_gain_scale.sv
module pi_gain_scale
    import pi_pkg::*;
#(
    parameter int NUM = 64,
    parameter int DEN = 125
) (
    input  pi_acc_t x_i,
    output pi_acc_t y_o
);

    localparam pi_acc_t K_NUM = pi_acc_t'(NUM);
    localparam pi_acc_t K_DEN = pi_acc_t'(DEN);

    pi_acc_t prod_w;

    // Signed divide truncates toward zero.
    always_comb begin
        prod_w = x_i * K_NUM;
        y_o    = prod_w / K_DEN;
    end

endmodule

// File: rtl/pi_sat_narrow.sv
module pi_sat_narrow
    import pi_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  pi_acc_t                  x_i,
    output logic signed [DATA_W-1:0] y_o,
    output logic                     hi_o,
    output logic                     lo_o
);

    localparam longint HI_L = (longint'(1) <<< (DATA_W-1)) - 1;
    localparam longint LO_L = -(longint'(1) <<< (DATA_W-1));
    localparam pi_acc_t HI  = pi_acc_t'(HI_L);
    localparam pi_acc_t LO  = pi_acc_t'(LO_L);

    pi_acc_t clip_w;

    always_comb begin
        hi_o = (x_i > HI);
        lo_o = (x_i < LO);
        if (hi_o)
            clip_w = HI;
        else if (lo_o)
            clip_w = LO;
        else
            clip_w = x_i;
        y_o = clip_w[DATA_W-1:0];
    end

endmodule

// File: rtl/pi_fixed_loop.sv
module pi_fixed_loop
    import pi_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int KP_NUM = 64,
    parameter int KP_DEN = 125,
    parameter int KI_NUM = 51,
    parameter int KI_DEN = 1250
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick_i,
    input  logic signed [DATA_W-1:0] setpt_i,
    input  logic signed [DATA_W-1:0] meas_i,
    output logic signed [DATA_W-1:0] cmd_o,
    output logic                     cmd_vld_o
);

    localparam logic signed [DATA_W-1:0] CMD_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] CMD_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        pi_acc_t                  integ;
        logic signed [DATA_W-1:0] cmd;
        logic                     vld;
    } loop_st_t;

    loop_st_t st_d;
    loop_st_t st_q;

    pi_acc_t                  err_w;
    pi_acc_t                  kp_term_w;
    pi_acc_t                  ki_term_w;
    pi_acc_t                  integ_upd_w;
    pi_acc_t                  sum_w;
    logic signed [DATA_W-1:0] cmd_nar_w;
    logic                     sat_hi_w;
    logic                     sat_lo_w;

    pi_err_calc #(.DATA_W(DATA_W)) u_err (
        .setpt_i (setpt_i),
        .meas_i  (meas_i),
        .err_o   (err_w)
    );

    pi_gain_scale #(.NUM(KP_NUM), .DEN(KP_DEN)) u_kp (
        .x_i (err_w),
        .y_o (kp_term_w)
    );

    pi_gain_scale #(.NUM(KI_NUM), .DEN(KI_DEN)) u_ki (
        .x_i (err_w),
        .y_o (ki_term_w)
    );

    // The command uses the integral after this sample's update.
    always_comb begin
        integ_upd_w = pi_sat_add(st_q.integ, ki_term_w);
        sum_w       = pi_sat_add(kp_term_w, integ_upd_w);
    end

    pi_sat_narrow #(.DATA_W(DATA_W)) u_nar (
        .x_i  (sum_w),
        .y_o  (cmd_nar_w),
        .hi_o (sat_hi_w),
        .lo_o (sat_lo_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (tick_i) begin
            st_d.integ = integ_upd_w;
            st_d.cmd   = cmd_nar_w;
            st_d.vld   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o     = st_q.cmd;
    assign cmd_vld_o = st_q.vld;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cmd_o == '0 && !cmd_vld_o && st_q.integ == '0));

    // R7
    vld_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> cmd_vld_o);

    // R7
    vld_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> !cmd_vld_o);

    // R8
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> ($stable(cmd_o) && $stable(st_q.integ)));

    // R6
    clamp_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && sat_hi_w) |=> (cmd_o == CMD_MAX));

    // R6
    clamp_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && sat_lo_w) |=> (cmd_o == CMD_MIN));

endmodule

// File: tb/sim_pi_fixed_loop.sv
module sim_pi_fixed_loop;

    localparam int DATA_W = 16;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     tick = 1'b0;
    logic signed [DATA_W-1:0] setpt = '0;
    logic signed [DATA_W-1:0] meas = '0;
    logic signed [DATA_W-1:0] cmd;
    logic                     cmd_vld;

    int n_chk = 0;
    int n_fail = 0;

    longint m_integ = 0;
    longint exp_q[$];
    string  tag_q[$];

    always #2 clk = ~clk;

    pi_fixed_loop #(.DATA_W(DATA_W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .setpt_i   (setpt),
        .meas_i    (meas),
        .cmd_o     (cmd),
        .cmd_vld_o (cmd_vld)
    );

    function automatic longint clip(input longint v, input longint lo, input longint hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: one strobe, with the expected result pushed to the scoreboard.
    task automatic sample(input int sp, input int ms, input string req);
        longint e, p, s;
        @(negedge clk);
        setpt = DATA_W'(sp);
        meas  = DATA_W'(ms);
        tick  = 1'b1;
        e = longint'(sp) - longint'(ms);
        p = (64 * e) / 125;
        m_integ = clip(m_integ + (51 * e) / 1250, -64'sd2147483648, 64'sd2147483647);
        s = clip(p + m_integ, -64'sd2147483648, 64'sd2147483647);
        exp_q.push_back(clip(s, -32768, 32767));
        tag_q.push_back(req);
        @(posedge clk);
        #1 tick = 1'b0;
    endtask

    // Idle with stray inputs, checking that nothing moves (R7, R8).
    task automatic idle_hold(input int n);
        logic signed [DATA_W-1:0] held;
        @(negedge clk);
        held = cmd;
        for (int i = 0; i < n; i++) begin
            setpt = DATA_W'(i * 977 - 3000);
            meas  = DATA_W'(1234 - i * 311);
            @(negedge clk);
            check("R7 no valid without strobe", longint'(cmd_vld), 0);
            check("R8 command held", longint'(cmd), longint'(held));
        end
    endtask

    // Monitor: pop and compare on each valid pulse.
    always @(negedge clk) begin
        if (!rst && cmd_vld) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected valid", 1, 0);
            end else begin
                string t;
                longint x;
                x = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, longint'(cmd), x);
            end
        end
    end

    initial begin
        #600000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset command", longint'(cmd), 0);
        check("R1 reset valid", longint'(cmd_vld), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R3 R4 R5: e=125 gives p=64, i=5, command 69
        sample(200, 75, "R5 first sample");
        idle_hold(3);
        // R3: truncation toward zero on small negative errors
        sample(0, 2, "R3 negative trunc");
        sample(0, 1, "R3 minus one");
        sample(-7, 17, "R4 small error no integral");
        // R2: mixed signs
        sample(-300, 450, "R2 mixed sign error");
        sample(1000, -1000, "R2 positive span");
        idle_hold(4);

        // R7: back-to-back strobes
        for (int k = 0; k < 6; k++)
            sample(k * 500 - 1000, 250, "R7 back-to-back");
        idle_hold(2);

        // R6: full-scale error saturates high and low
        sample(32767, -32768, "R6 clamp high");
        sample(-32768, 32767, "R6 clamp low");
        sample(0, 0, "R8 zero error keeps integral");

        // R6: wind the integral up, then hold at limit with zero error
        for (int k = 0; k < 20; k++)
            sample(32767, -32768, "R6 windup high");
        sample(5, 5, "R6 integral alone saturates");
        for (int k = 0; k < 40; k++)
            sample(-32768, 32767, "R6 unwind to low");
        idle_hold(3);

        // R9: mid-run reset discards the integral
        @(negedge clk);
        rst = 1'b1;
        m_integ = 0;
        repeat (2) @(negedge clk);
        check("R9 reset command", longint'(cmd), 0);
        check("R9 reset valid", longint'(cmd_vld), 0);
        rst = 1'b0;
        sample(200, 75, "R9 after reset");
        sample(12, 12, "R9 integral restarted");
        for (int k = 0; k < 30; k++)
            sample(k * 2000 - 30000, -k * 1500 + 20000, "R4 sweep");
        idle_hold(3);

        check("R7 scoreboard drained", longint'(exp_q.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule